// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a small up-counter that steps through the binary values of its state register on each rising clock edge, wrapping from all ones back to zero. With the default width of four bits it counts modulo 16. Active-low inputs choose among four operations with a fixed precedence: clearing, loading a parallel word, counting, and holding.

Counting requires two enables to be high together. One of them, the chain enable, also gates the carry output. The carry is high only when the state is all ones and the chain enable is high. Several copies can therefore be chained into a wider synchronous counter. Each stage's carry feeds the next stage's chain enable, and every stage shares the run enable and the clock.

A parameter picks how the clear acts. In the default variant the clear takes effect on the next rising edge. In the other variant it forces the state to zero at once, with no clock edge needed.

Top module: `casc_bin_counter`

## Requirements
- R1: With the default width of 4 bits, counting from state 15 (all ones) gives state 0 on the next rising edge. In general the count runs modulo 2^WIDTH.
- R2: In the default (clocked-clear) variant, the state changes only at a rising edge of `clk`. Input changes between edges leave `q` unchanged until the next rising edge.
- R3: In the clocked-clear variant, a low `clr_n` at a rising edge makes `q` equal 0 after that edge, whatever `load_n`, `run_en` and `chain_en` are. The state does not change before that edge.
- R4: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` after that edge, whatever the two count enables are.
- R5: When `clr_n` and `load_n` are high and both `run_en` and `chain_en` are high at a rising edge, `q` increases by one.
- R6: When `clr_n` and `load_n` are high and either `run_en` or `chain_en` is low at a rising edge, `q` keeps its value.
- R7: `carry_out` is 1 exactly when `q` is all ones (15 at the default width) and `chain_en` is 1. It is combinational, and `run_en` has no effect on it.
- R8: With `ASYNC_CLEAR` set to 1, a low on `clr_n` forces `q` to 0 at once, with no clock edge. While `clr_n` stays low, the state stays 0 across edges, even with `load_n` low.
- R9: When two stages are chained, with the lower stage's `carry_out` driving the upper stage's `chain_en` and `run_en` shared, the pair counts from 0 through 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all changes happen on the rising edge, except the immediate clear |
| clr_n | input | 1 | Active-low clear; clocked or immediate, chosen by `ASYNC_CLEAR` |
| load_n | input | 1 | Active-low parallel load of `din` |
| run_en | input | 1 | Count enable shared by all stages; does not affect the carry |
| chain_en | input | 1 | Count enable that also gates `carry_out` |
| din | input | WIDTH | Parallel load word |
| q | output | WIDTH | Counter state |
| carry_out | output | 1 | High when the state is all ones and `chain_en` is high |

## Verification
The assertions assume that the control inputs and `din` are steady around each rising edge. They also assume that `clr_n` only changes away from the edge in the immediate-clear variant. Each check relates the values sampled at one edge to the state after it. The bench drives every input at the falling edge, or a few time units after it, and samples `q` and `carry_out` just before the next change. Sweeps cover every load value, every state paired with every combination of the two enables, and a full 256-step run of a two-stage chain, with the expected values computed arithmetically.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   // Operation chosen for the next rising edge, highest precedence first
   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_COUNT = 2'd2,
      OP_HOLD  = 2'd3
   } cbc_op_t;

endpackage

// File: rtl/cbc_op_decode.sv
module cbc_op_decode
   import cbc_pkg::*;
(
   input  logic    clr_n,
   input  logic    load_n,
   input  logic    run_en,
   input  logic    chain_en,
   output cbc_op_t op
);

   // Fixed precedence: clear, load, count, hold
   always_comb begin
      if (!clr_n)
         op = OP_CLEAR;
      else if (!load_n)
         op = OP_LOAD;
      else if (run_en && chain_en)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/cbc_next_state.sv
module cbc_next_state
   import cbc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  cbc_op_t          op,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = din;
         OP_COUNT: nxt = cur + STEP;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/cbc_state_reg.sv
module cbc_state_reg #(
   parameter int WIDTH       = 4,
   parameter bit ASYNC_CLEAR = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);

   generate
      if (ASYNC_CLEAR) begin : g_async_clear
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)
               q <= '0;
            else
               q <= nxt;
         end
      end else begin : g_sync_clear
         // Clear is already folded into nxt by the decoder
         always_ff @(posedge clk) begin
            q <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/cbc_carry.sv
module cbc_carry #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] q,
   input  logic             chain_en,
   output logic             carry_out
);

   // Ripple AND across the state bits, built per bit
   logic [WIDTH:0] all_ones;

   assign all_ones[0] = chain_en;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign all_ones[b+1] = all_ones[b] & q[b];
      end
   endgenerate

   assign carry_out = all_ones[WIDTH];

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
   import cbc_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter bit ASYNC_CLEAR = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             run_en,
   input  logic             chain_en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry_out
);

   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("casc_bin_counter: WIDTH must lie in 1..64");
      end
   endgenerate

   cbc_op_t          op;
   logic [WIDTH-1:0] nxt;

   cbc_op_decode u_decode (
      .clr_n    (clr_n),
      .load_n   (load_n),
      .run_en   (run_en),
      .chain_en (chain_en),
      .op       (op)
   );

   cbc_next_state #(.WIDTH(WIDTH)) u_next (
      .op  (op),
      .cur (q),
      .din (din),
      .nxt (nxt)
   );

   cbc_state_reg #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .q     (q)
   );

   cbc_carry #(.WIDTH(WIDTH)) u_carry (
      .q         (q),
      .chain_en  (chain_en),
      .carry_out (carry_out)
   );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
   parameter int WIDTH       = 4,
   parameter bit ASYNC_CLEAR = 1'b0
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic             run_en,
   input logic             chain_en,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] q,
   input logic             carry_out
);

   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);
   localparam logic [WIDTH-1:0] TOP  = '1;

   // Becomes 1 after the first edge so nothing looks at pre-clock values
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   assert_clear_R3: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> (q == '0));

   assert_load_R4: assert property (@(posedge clk) disable iff (!armed || !clr_n)
      !load_n |=> (q == $past(din)));

   assert_count_R5: assert property (@(posedge clk) disable iff (!armed || !clr_n)
      (load_n && run_en && chain_en) |=> (q == $past(q) + STEP));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!armed || !clr_n)
      (load_n && !(run_en && chain_en)) |=> $stable(q));

   assert_carry_state_R7: assert property (@(posedge clk) disable iff (!armed)
      carry_out |-> (q == TOP));

   assert_carry_gate_R7: assert property (@(posedge clk) disable iff (!armed)
      !chain_en |-> !carry_out);

   generate
      if (ASYNC_CLEAR) begin : g_async_chk
         assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!armed)
            (!clr_n && !$past(clr_n)) |-> (q == '0));
      end
   endgenerate

endmodule

bind casc_bin_counter cbc_checker #(
   .WIDTH       (WIDTH),
   .ASYNC_CLEAR (ASYNC_CLEAR)
) i_cbc_checker (
   .clk       (clk),
   .clr_n     (clr_n),
   .load_n    (load_n),
   .run_en    (run_en),
   .chain_en  (chain_en),
   .din       (din),
   .q         (q),
   .carry_out (carry_out)
);

// File: tb/test_casc_bin_counter.sv
module test_casc_bin_counter;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Shared controls for the chained pair
   logic       clr_n   = 1'b0;
   logic       load_n  = 1'b1;
   logic       run_en  = 1'b0;
   logic       lo_chain = 1'b0;
   logic [3:0] din_lo  = '0;
   logic [3:0] din_hi  = '0;
   logic [3:0] q_lo, q_hi;
   logic       carry_lo, carry_hi;

   // Immediate-clear instance
   logic       a_clr_n  = 1'b0;
   logic       a_load_n = 1'b1;
   logic [3:0] a_din    = '0;
   logic [3:0] a_q;
   logic       a_carry;

   casc_bin_counter i_casc_bin_counter (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .run_en(run_en),
      .chain_en(lo_chain), .din(din_lo), .q(q_lo), .carry_out(carry_lo));

   casc_bin_counter i_casc_upper (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .run_en(run_en),
      .chain_en(carry_lo), .din(din_hi), .q(q_hi), .carry_out(carry_hi));

   casc_bin_counter #(.ASYNC_CLEAR(1'b1)) i_async (
      .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .run_en(1'b0),
      .chain_en(1'b0), .din(a_din), .q(a_q), .carry_out(a_carry));

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   // One rising edge, then return at the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 3000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int exp;
      @(negedge clk);
      // R3: clear overrides load and count
      clr_n = 1'b0; load_n = 1'b0; run_en = 1'b1; lo_chain = 1'b1;
      din_lo = 4'd5; din_hi = 4'd6;
      tick();
      check("R3 reset lo", q_lo, 0);
      check("R3 reset hi", q_hi, 0);
      clr_n = 1'b1;

      // R4: every load value, both enables high
      for (int v = 0; v < 16; v++) begin
         load_n = 1'b0; din_lo = 4'(v); din_hi = 4'(15 - v);
         tick();
         check("R4 load lo", q_lo, v);
         check("R4 load hi", q_hi, 15 - v);
      end

      // R7: carry for every state and enable pair, combinational
      lo_chain = 1'b0; run_en = 1'b0;
      for (int v = 0; v < 16; v++) begin
         load_n = 1'b0; din_lo = 4'(v);
         tick();
         load_n = 1'b1;
         for (int e = 0; e < 4; e++) begin
            run_en = e[0]; lo_chain = e[1];
            #1;
            check("R7 carry", carry_lo, (v == 15 && e[1]) ? 1 : 0);
         end
         run_en = 1'b0; lo_chain = 1'b0;
      end

      // R6: hold with either enable low
      load_n = 1'b0; din_lo = 4'd9; din_hi = 4'd0;
      tick();
      load_n = 1'b1;
      for (int e = 0; e < 3; e++) begin
         run_en = e[0]; lo_chain = e[1];
         tick();
         check("R6 hold", q_lo, 9);
      end

      // R5, R1: count from 13 across the wrap
      load_n = 1'b0; din_lo = 4'd13;
      tick();
      load_n = 1'b1; run_en = 1'b1; lo_chain = 1'b1;
      for (int k = 1; k <= 6; k++) begin
         tick();
         check("R5 R1 count", q_lo, (13 + k) % 16);
      end

      // R2: mid-cycle changes do not move the state
      exp = q_lo;
      run_en = 1'b0;
      #2; run_en = 1'b1; load_n = 1'b0; din_lo = 4'd3;
      #2;
      check("R2 no change between edges", q_lo, exp);
      load_n = 1'b1;
      tick();
      check("R2 change at edge", q_lo, (exp + 1) % 16);
      // R3: clocked clear waits for the edge
      clr_n = 1'b0;
      #2;
      check("R3 clear waits for edge", q_lo, (exp + 1) % 16);
      tick();
      check("R3 clear at edge", q_lo, 0);
      clr_n = 1'b1;

      // R9: two-stage chain runs 0..255 and wraps
      run_en = 1'b1; lo_chain = 1'b1; load_n = 1'b1;
      check("R9 start", {q_hi, q_lo}, 0);
      for (int k = 1; k <= 257; k++) begin
         tick();
         check("R9 cascade", {q_hi, q_lo}, k % 256);
      end
      run_en = 1'b0;

      // R8: immediate clear
      a_clr_n = 1'b1; a_load_n = 1'b0; a_din = 4'd11;
      tick();
      check("R8 async load", a_q, 11);
      #2; a_clr_n = 1'b0;
      #1;
      check("R8 immediate clear", a_q, 0);
      tick();
      check("R8 clear held over load", a_q, 0);
      #2; a_clr_n = 1'b1;
      tick();
      check("R8 load after release", a_q, 11);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule